// File: doc/BRIEF.md
# Bus Edge Capture/Compare Timer

This timer lets a node answer a bit slot on a single-wire bus with a low pulse of a set width. A master opens every bit slot by pulling the bus low, and it does so even when the slave is the one sending. A counter runs without stopping and advances at a fixed tick rate. Each falling edge of the bus copies the counter's value into a capture register. Software reads that value, adds the width it wants, and writes the sum into the compare register. When the counter reaches that value, a status flag is set. If the matching enable is on, the interrupt line goes high and software releases the bus.

The same edge detector sets a start-condition flag on every high-to-low bus transition. With its enable on, that flag can wake a sleeping core. The flags are cleared by writing a one to them. The interrupt output is the OR of the flags whose enables are set.

Top module: `ctc_timer`

## Requirements
- R1: The counter is W bits wide and starts at 0 after reset. It advances by one every DIV clock cycles, wraps to zero modulo 2^W, and bus activity never resets or stops it.
- R2: The bus input passes through a two-stage synchroniser. Each falling edge at the synchroniser output writes the counter into the capture register (register index 2). If the bus goes low just before clock edge m+1, the captured value is the count after edge m+2. Rising edges do not change the capture register.
- R3: A write to the compare register (register index 3) arms the comparison. When the counter then equals the compare value, bit 3 of the status register (index 1) is set.
- R4: A compare write produces at most one match. Once it has matched, a full counter wrap with no new write sets nothing.
- R5: The compare is an equality test on the wrapping counter. A compare value that lies past the wrap point matches after the rollover.
- R6: Each synchronised falling edge of the bus sets bit 1 of the status register, the start-condition flag.
- R7: Writing a 1 to a status bit clears it. Writing a 0 leaves it unchanged. A set event in the same cycle takes priority over the clear.
- R8: irq_o is high when bit 1 of the status register is set and control bit 0 (start enable, register index 0) is set, or when bit 3 is set and control bit 1 (compare enable) is set. A status flag is still set while its enable is off.
- R9: After reset, the control, status, capture and compare registers read 0 and irq_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_i | input | 1 | Raw bus line level |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register index: 0 control, 1 status, 2 capture, 3 compare |
| wdata_i | input | W | Write data |
| rdata_o | output | W | Read data for addr_i (combinational) |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest case to reach is a compare value that lies beyond the counter's wrap point. The stimulus gets there by following the counter in a model, waiting until the value to be captured is 250 of 256, and then pulling the bus low. It then writes capture plus 20 so that the match lands after the rollover. The same model then waits through a whole wrap after a match and watches that the interrupt does not rise again. Every interrupt rise is checked against the exact cycle the model predicts for it.

// File: rtl/ctc_pkg.sv
package ctc_pkg;
   typedef enum logic [1:0] {
      REG_CTRL = 2'd0,
      REG_STAT = 2'd1,
      REG_CAP  = 2'd2,
      REG_CMP  = 2'd3
   } ctc_reg_e;

   localparam int CTRL_START_EN = 0;
   localparam int CTRL_CMP_EN   = 1;
   localparam int STAT_START    = 1;
   localparam int STAT_CMP      = 3;
endpackage

// File: rtl/ctc_edge_sync.sv
module ctc_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic bus_i,
   output logic fall_o
);
   // sh_q[STAGES-1] is the synchronised level, sh_q[STAGES] is its previous value
   logic [STAGES:0] sh_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sh_q <= '1;
      else         sh_q <= {sh_q[STAGES-1:0], bus_i};
   end

   assign fall_o = sh_q[STAGES] & ~sh_q[STAGES-1];
endmodule

// File: rtl/ctc_free_counter.sv
module ctc_free_counter #(
   parameter int W   = 16,
   parameter int DIV = 40
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   output logic [W-1:0] cnt_o
);
   logic tick;

   generate
      if (DIV == 1) begin : g_direct
         assign tick = 1'b1;
      end else begin : g_prescale
         localparam int PW = $clog2(DIV);
         localparam logic [PW-1:0] LAST = PW'(DIV - 1);
         logic [PW-1:0] pre_q;
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni)            pre_q <= '0;
            else if (pre_q == LAST) pre_q <= '0;
            else                    pre_q <= pre_q + PW'(1);
         end
         assign tick = (pre_q == LAST);
      end
   endgenerate

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   cnt_o <= '0;
      else if (tick) cnt_o <= cnt_o + W'(1);
   end
endmodule

// File: rtl/ctc_compare.sv
module ctc_compare #(
   parameter int W = 16
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic [W-1:0] cnt_i,
   input  logic         wr_i,
   input  logic [W-1:0] data_i,
   output logic [W-1:0] cmp_o,
   output logic         armed_o,
   output logic         hit_o
);
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cmp_o   <= '0;
         armed_o <= 1'b0;
      end else if (wr_i) begin
         cmp_o   <= data_i;
         armed_o <= 1'b1;
      end else if (hit_o) begin
         armed_o <= 1'b0;
      end
   end

   assign hit_o = armed_o & (cnt_i == cmp_o);
endmodule

// File: rtl/ctc_timer.sv
module ctc_timer
   import ctc_pkg::*;
#(
   parameter int W      = 16,
   parameter int DIV    = 40,
   parameter int STAGES = 2
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         bus_i,
   input  logic         wr_en_i,
   input  logic [1:0]   addr_i,
   input  logic [W-1:0] wdata_i,
   output logic [W-1:0] rdata_o,
   output logic         irq_o
);
   generate
      if (W < 4) begin : g_bad_w
         $error("ctc_timer: W must be at least 4");
      end
      if (DIV < 1) begin : g_bad_div
         $error("ctc_timer: DIV must be at least 1");
      end
      if (STAGES < 2) begin : g_bad_sync
         $error("ctc_timer: STAGES must be at least 2");
      end
   endgenerate

   logic [W-1:0] cnt_q;
   logic [W-1:0] cap_q;
   logic [W-1:0] cmp_val;
   logic [1:0]   ctrl_q;
   logic         start_flag_q;
   logic         cmp_flag_q;
   logic         bus_fall;
   logic         cmp_hit;
   logic         cmp_armed;
   logic         cmp_wr;
   logic         ctrl_wr;
   logic         stat_wr;

   assign ctrl_wr = wr_en_i && (addr_i == REG_CTRL);
   assign stat_wr = wr_en_i && (addr_i == REG_STAT);
   assign cmp_wr  = wr_en_i && (addr_i == REG_CMP);

   ctc_edge_sync #(.STAGES(STAGES)) u_sync (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .bus_i (bus_i),
      .fall_o(bus_fall)
   );

   ctc_free_counter #(.W(W), .DIV(DIV)) u_cnt (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .cnt_o (cnt_q)
   );

   ctc_compare #(.W(W)) u_cmp (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .cnt_i  (cnt_q),
      .wr_i   (cmp_wr),
      .data_i (wdata_i),
      .cmp_o  (cmp_val),
      .armed_o(cmp_armed),
      .hit_o  (cmp_hit)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         ctrl_q       <= '0;
         cap_q        <= '0;
         start_flag_q <= 1'b0;
         cmp_flag_q   <= 1'b0;
      end else begin
         if (ctrl_wr)  ctrl_q <= wdata_i[1:0];
         if (bus_fall) cap_q  <= cnt_q;
         start_flag_q <= (start_flag_q & ~(stat_wr & wdata_i[STAT_START])) | bus_fall;
         cmp_flag_q   <= (cmp_flag_q & ~(stat_wr & wdata_i[STAT_CMP])) | cmp_hit;
      end
   end

   always_comb begin
      rdata_o = '0;
      case (ctc_reg_e'(addr_i))
         REG_CTRL: rdata_o[1:0] = ctrl_q;
         REG_STAT: begin
            rdata_o[STAT_START] = start_flag_q;
            rdata_o[STAT_CMP]   = cmp_flag_q;
         end
         REG_CAP:  rdata_o = cap_q;
         REG_CMP:  rdata_o = cmp_val;
         default:  rdata_o = '0;
      endcase
   end

   assign irq_o = (start_flag_q & ctrl_q[CTRL_START_EN]) |
                  (cmp_flag_q & ctrl_q[CTRL_CMP_EN]);
endmodule

module ctc_timer_chk #(
   parameter int W = 16
) (
   input logic         clk_i,
   input logic         rst_ni,
   input logic [W-1:0] cnt,
   input logic [W-1:0] cap,
   input logic         fall,
   input logic         start_flag,
   input logic         cmp_flag,
   input logic [1:0]   ctrl,
   input logic         irq,
   input logic         hit,
   input logic         armed,
   input logic         cmp_wr
);
   // R1
   cnt_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cnt != $past(cnt)) |-> (cnt == $past(cnt) + W'(1)));

   // R2
   cap_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !fall |=> $stable(cap));

   // R3
   cmp_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hit |=> cmp_flag);

   // R4
   one_shot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (hit && !cmp_wr) |=> !armed);

   // R6
   start_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fall |=> start_flag);

   // R8
   irq_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ctrl == 2'b00) |-> !irq);
endmodule

bind ctc_timer ctc_timer_chk #(.W(W)) u_chk (
   .clk_i     (clk_i),
   .rst_ni    (rst_ni),
   .cnt       (cnt_q),
   .cap       (cap_q),
   .fall      (bus_fall),
   .start_flag(start_flag_q),
   .cmp_flag  (cmp_flag_q),
   .ctrl      (ctrl_q),
   .irq       (irq_o),
   .hit       (cmp_hit),
   .armed     (cmp_armed),
   .cmp_wr    (cmp_wr)
);

// File: tb/ctc_timer_bench.sv
module ctc_timer_bench;
   localparam int W   = 8;
   localparam int DIV = 3;
   localparam int MOD = 1 << W;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         bus = 1'b1;
   logic         wr_en = 1'b0;
   logic [1:0]   addr = 2'd0;
   logic [W-1:0] wdata = '0;
   logic [W-1:0] rdata;
   logic         irq;

   int vectors = 0;
   int fails = 0;
   int n = 0;
   int exp_q[$];
   bit done = 0;
   bit irq_prev = 0;

   always #2.5 clk = ~clk;

   ctc_timer #(.W(W), .DIV(DIV)) u_ctc_timer (
      .clk_i(clk), .rst_ni(rst_n), .bus_i(bus), .wr_en_i(wr_en),
      .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
   );

   // counts clock edges since reset release
   always @(posedge clk) if (rst_n) n <= n + 1;

   function automatic int model_cnt(int k);
      return (k / DIV) % MOD;
   endfunction

   function automatic int cmp_rise(int m, int v);
      for (int k = m + 1; k < m + 2 + MOD * DIV + DIV; k++)
         if (model_cnt(k) == v) return k + 1;
      return -1;
   endfunction

   task automatic check(string req, int act, int exp);
      vectors++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic wr(logic [1:0] a, int d);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wdata = W'(d);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(logic [1:0] a, output int v);
      addr = a;
      #1;
      v = int'(rdata);
   endtask

   task automatic drain(int max, string req);
      for (int i = 0; i < max && exp_q.size() != 0; i++) @(negedge clk);
      if (exp_q.size() != 0) begin
         vectors++; fails++;
         $display("FAIL %s: actual no irq expected irq at cycle %0d", req, exp_q[0]);
         exp_q.delete();
      end
   endtask

   // monitor: every irq rise must match the front of the scoreboard
   always @(negedge clk) begin
      if (rst_n) begin
         if (irq && !irq_prev) begin
            vectors++;
            if (exp_q.size() == 0) begin
               fails++;
               $display("FAIL R4: actual irq rise at cycle %0d expected none", n);
            end else begin
               int e;
               e = exp_q.pop_front();
               if (e != n) begin
                  fails++;
                  $display("FAIL R8: actual irq rise cycle %0d expected %0d", n, e);
               end
            end
         end
         irq_prev = irq;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end

   initial begin
      int v, m, cap, cmpv, rise;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R9 reset state
      rd(2'd0, v); check("R9 ctrl", v, 0);
      rd(2'd1, v); check("R9 stat", v, 0);
      rd(2'd2, v); check("R9 cap", v, 0);
      rd(2'd3, v); check("R9 cmp", v, 0);
      check("R9 irq", int'(irq), 0);

      // R2/R6 capture and start flag with irqs disabled (R8)
      repeat (7) @(negedge clk);
      m = n; bus = 1'b0;
      repeat (5) @(negedge clk);
      rd(2'd2, cap); check("R2 capture", cap, model_cnt(m + 2));
      rd(2'd1, v); check("R6 start flag", v, 2);
      check("R8 irq gated off", int'(irq), 0);
      bus = 1'b1;
      repeat (8) @(negedge clk);
      rd(2'd2, v); check("R2 rising edge ignored", v, cap);
      wr(2'd1, 8);
      rd(2'd1, v); check("R7 write 0 keeps flag", v, 2);
      wr(2'd1, 2);
      rd(2'd1, v); check("R7 clear start", v, 0);

      // R3 compare with both irqs enabled
      wr(2'd0, 3);
      repeat (4) @(negedge clk);
      m = n; exp_q.push_back(m + 3); bus = 1'b0;
      drain(10, "R6");
      rd(2'd2, cap); check("R1 capture tracks counter", cap, model_cnt(m + 2));
      wr(2'd1, 2);
      bus = 1'b1;
      cmpv = (cap + 20) % MOD;
      m = n; rise = cmp_rise(m, cmpv); exp_q.push_back(rise);
      wr(2'd3, cmpv);
      drain(200, "R3");
      rd(2'd1, v); check("R3 compare flag", v, 8);
      rd(2'd3, v); check("R3 compare readback", v, cmpv);
      wr(2'd1, 8);
      // R4: a full wrap with no new write raises nothing
      repeat (MOD * DIV + 10) @(negedge clk);
      rd(2'd1, v); check("R4 no second match", v, 0);

      // R5 compare past the wrap point
      while (model_cnt(n + 2) != MOD - 6) @(negedge clk);
      m = n; exp_q.push_back(m + 3); bus = 1'b0;
      drain(10, "R6");
      rd(2'd2, cap); check("R5 capture near wrap", cap, MOD - 6);
      wr(2'd1, 2);
      bus = 1'b1;
      cmpv = (cap + 20) % MOD;
      m = n; rise = cmp_rise(m, cmpv); exp_q.push_back(rise);
      wr(2'd3, cmpv);
      drain(200, "R5");
      rd(2'd1, v); check("R5 match after rollover", v, 8);
      wr(2'd1, 8);

      // R8 compare enable off: flag sets, irq stays low
      wr(2'd0, 1);
      m = n; cmpv = (model_cnt(m) + 4) % MOD; rise = cmp_rise(m, cmpv);
      wr(2'd3, cmpv);
      while (n < rise + 2) @(negedge clk);
      rd(2'd1, v); check("R8 flag set while disabled", v, 8);
      check("R8 irq low while disabled", int'(irq), 0);
      wr(2'd1, 8);
      rd(2'd1, v); check("R7 clear compare", v, 0);

      repeat (5) @(negedge clk);
      check("R8 scoreboard empty", exp_q.size(), 0);
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end
endmodule